// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of a 1024-row dynamic memory alive by asking the access controller for a refresh slot at a fixed interval. When the slot is granted, it drives the row and column strobes, the write enable and the address through one complete refresh cycle. With the default parameters and a 125 MHz clock, the interval is 1950 cycles. That gives one row about every 15.6 us, so all rows are covered within 16 ms.

Three styles are selectable per refresh:
- **Row-strobe-only:** the block supplies the row from its own 10-bit counter and keeps the column strobe high.
- **Column-first:** the column strobe falls ahead of the row strobe, so the memory uses its internal row counter.
- **Hidden:** the column strobe, left low by the access that just ended, stays low while the row strobe precharges and then falls again. This keeps read data valid.

Refresh requests that cannot be served at once are counted, up to a parameterised limit, so a postponed request is not lost. A tick that arrives while the count is already at the limit sets a sticky overrun flag.

The write enable is held high throughout every refresh. This means a column-first or hidden refresh can never be taken as a test-mode entry. All times are whole clock cycles:
- precharge: 5 cycles (40 ns)
- row strobe low: 9 cycles (72 ns)
- column lead: 1 cycle

A full cycle is therefore at least 112 ns.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, req, busy and overrun are 0, ras_n, cas_n and we_n are 1, and row_addr is 0.
- R2: The pending count rises by one every INTERVAL cycles after reset, and req is 1 exactly while the pending count is nonzero.
- R3: The pending count saturates at MAX_PEND. A tick that arrives while the count is full and no refresh starts in that cycle sets overrun, and overrun stays 1 until reset. Each accepted grant consumes exactly one pending request.
- R4: grant starts a refresh only when busy is 0 and req is 1. Otherwise it has no effect.
- R5: In row-strobe-only mode (ref_mode 2'b00), cas_n stays 1 for the whole refresh. ras_n is high for T_RP cycles and then low for T_RAS cycles while row_addr holds the row being refreshed.
- R6: The row counter on row_addr increments by one at the end of each row-strobe-only refresh and wraps from 1023 to 0. Other modes leave it unchanged.
- R7: In column-first mode (ref_mode 2'b01 or 2'b11), the sequence is:
  - after T_RP precharge cycles, cas_n falls;
  - T_CSR cycles later, ras_n falls;
  - both stay low for T_RAS cycles and rise together.
- R8: we_n is 1 in every cycle, including the cycle before and the cycles after any falling edge of ras_n.
- R9: In hidden mode (ref_mode 2'b10), cas_n is 0 in every busy cycle. ras_n is high for T_RP cycles and then low for T_RAS cycles.
- R10: busy is 1 from the cycle after an accepted grant for exactly T_RP+T_RAS cycles, or T_RP+T_CSR+T_RAS cycles in column-first mode. ref_mode is sampled at the accepted grant only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_mode | input | 2 | Refresh style: 00 row-strobe-only, 01/11 column-first, 10 hidden |
| grant | input | 1 | Slot granted by the access controller |
| req | output | 1 | Refresh wanted (pending count nonzero) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| row_addr | output | ROW_W | Row counter driven as address |
| busy | output | 1 | A refresh sequence is running |
| overrun | output | 1 | Sticky: a request was lost at the pending limit |

## Verification
The bench runs 1030 back-to-back row-strobe-only refreshes so that the row counter has to wrap. A design with a wrong counter width, or one that advances the counter in other modes, would show a row_addr that departs from the model. It withholds the grant long enough to saturate the pending count, which catches an overrun flag that never sets, that clears, or that sets one tick early, and it then drains the backlog. Grants are held high while a refresh is running, and a grant is pulsed while nothing is pending. These catch a design that restarts a sequence early or that refreshes without a request. Mode changes in the middle of a sequence catch a design that fails to latch the style when the grant is accepted, because the strobe shape would then change mid-cycle.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W    = 10,
  parameter int INTERVAL = 1950,
  parameter int T_RP     = 5,
  parameter int T_RAS    = 9,
  parameter int T_CSR    = 1,
  parameter int MAX_PEND = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ref_mode,
  input  logic             grant,
  output logic             req,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             busy,
  output logic             overrun
);
  localparam int TMR_W  = $clog2(INTERVAL + 1);
  localparam int PEND_W = $clog2(MAX_PEND + 1);
  localparam int CNT_W  = $clog2(T_RP + T_RAS + T_CSR + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_CSR, S_ACT} st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [PEND_W-1:0] pend;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       mode_q;
  logic             tick, start, col_first, hidden;

  assign tick      = (tmr == TMR_W'(INTERVAL - 1));
  assign req       = (pend != '0);
  assign start     = (st == S_IDLE) && grant && req;
  assign busy      = (st != S_IDLE);
  assign col_first = mode_q[0];
  assign hidden    = (mode_q == 2'b10);
  assign ras_n     = (st != S_ACT);
  assign cas_n     = !((col_first && (st == S_CSR || st == S_ACT)) || (hidden && busy));
  assign we_n      = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= '0;
    else if (tick) tmr <= '0;
    else tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      overrun <= 1'b0;
    end else if (tick && !start) begin
      if (pend == PEND_W'(MAX_PEND)) overrun <= 1'b1;
      else pend <= pend + 1'b1;
    end else if (!tick && start) begin
      pend <= pend - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      mode_q   <= 2'b00;
      row_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_PRE;
          cnt    <= CNT_W'(T_RP - 1);
          mode_q <= ref_mode;
        end
        S_PRE: if (cnt == '0) begin
          if (col_first) begin
            st  <= S_CSR;
            cnt <= CNT_W'(T_CSR - 1);
          end else begin
            st  <= S_ACT;
            cnt <= CNT_W'(T_RAS - 1);
          end
        end else cnt <= cnt - 1'b1;
        S_CSR: if (cnt == '0) begin
          st  <= S_ACT;
          cnt <= CNT_W'(T_RAS - 1);
        end else cnt <= cnt - 1'b1;
        S_ACT: if (cnt == '0) begin
          st <= S_IDLE;
          if (mode_q == 2'b00) row_addr <= row_addr + 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grant,
  input logic             req,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             busy,
  input logic             overrun,
  input logic [1:0]       mode_q
);
  p_we_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (we_n && $past(we_n)));

  p_col_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

  p_rasonly_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == 2'b00) |-> cas_n);

  p_hidden_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == 2'b10) |-> !cas_n);

  p_precharge_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ras_n);

  p_start_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req) && $past(grant));

  p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> !busy);

  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && cas_n && $past(cas_n)) |-> row_addr == ROW_W'($past(row_addr) + 1'b1));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr), .busy(busy),
  .overrun(overrun), .mode_q(mode_q)
);

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int ROW_W = 10, INT = 20, TRP = 5, TRAS = 9, TCSR = 1, MAXP = 3;

  logic clk = 1'b0, rst_n = 1'b0, grant = 1'b0;
  logic [1:0] mode = 2'b00;
  logic req, ras_n, cas_n, we_n, busy, overrun;
  logic [ROW_W-1:0] row_addr;
  int total = 0, bad = 0;
  bit wrapped = 0, done = 0;

  always #4 clk = ~clk;

  dram_refresh_sched #(.ROW_W(ROW_W), .INTERVAL(INT), .T_RP(TRP), .T_RAS(TRAS),
    .T_CSR(TCSR), .MAX_PEND(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_mode(mode), .grant(grant), .req(req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr),
    .busy(busy), .overrun(overrun));

  int m_tmr, m_pend, m_err, m_off, m_row;
  logic [1:0] m_mode;

  function automatic int seq_len(logic [1:0] md);
    return TRP + TRAS + (md[0] ? TCSR : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tmr = 0; m_pend = 0; m_err = 0; m_off = -1; m_row = 0; m_mode = 2'b00;
    end else begin
      automatic bit tk = (m_tmr == INT - 1);
      automatic bit st = (m_off < 0) && grant && (m_pend > 0);
      automatic int np;
      m_tmr = tk ? 0 : m_tmr + 1;
      if (m_off >= 0) begin
        m_off++;
        if (m_off == seq_len(m_mode)) begin
          if (m_mode == 2'b00) m_row = (m_row + 1) % 1024;
          m_off = -1;
        end
      end
      if (st) begin m_off = 0; m_mode = mode; end
      np = m_pend + int'(tk) - int'(st);
      if (np > MAXP) begin m_err = 1; np = MAXP; end
      m_pend = np;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int csr = m_mode[0] ? TCSR : 0;
      automatic bit e_ras = !(m_off >= TRP + csr);
      automatic bit e_cas = 1'b1;
      automatic string stag = (m_mode == 2'b00) ? "R5" : (m_mode == 2'b10) ? "R9" : "R7";
      if (m_off >= 0 && m_mode[0]) e_cas = !(m_off >= TRP);
      if (m_off >= 0 && m_mode == 2'b10) e_cas = 1'b0;
      chk("R2 req", req, m_pend > 0);
      chk("R3 overrun", overrun, m_err);
      chk("R10 R4 busy", busy, m_off >= 0);
      chk("R8 we_n", we_n, 1);
      chk("R6 row_addr", row_addr, m_row);
      chk({stag, " ras_n"}, ras_n, e_ras);
      chk({stag, " cas_n"}, cas_n, e_cas);
    end
  end

  always @(posedge clk) begin
    if (rst_n && row_addr == 10'd1023) @(negedge clk) if (row_addr == 10'd0) wrapped = 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req", req, 0); chk("R1 busy", busy, 0); chk("R1 overrun", overrun, 0);
    chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1); chk("R1 we_n", we_n, 1);
    chk("R1 row_addr", row_addr, 0);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk("R4 grant without req", busy, 0);
    mode = 2'b00; grant = 1'b1; repeat (100) @(negedge clk);
    mode = 2'b01; repeat (100) @(negedge clk);
    mode = 2'b11; repeat (100) @(negedge clk);
    mode = 2'b10; repeat (100) @(negedge clk);
    for (int i = 0; i < 7; i++) begin mode = 2'(i); repeat (9) @(negedge clk); end
    grant = 1'b0; repeat (6 * INT) @(negedge clk);
    chk("R3 overrun set at limit", overrun, 1);
    mode = 2'b10; grant = 1'b1; repeat (200) @(negedge clk);
    mode = 2'b00; repeat (1030 * INT) @(negedge clk);
    chk("R6 row wrapped", wrapped, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule